// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Loader

This block is the digital front end of a two-channel 12-bit converter. A host sends 16-bit words over a three-wire serial link: an active-low frame strobe, a serial clock and a data line. Each word carries a channel-select bit and a 12-bit code. The block stores the code in that channel's holding latch. The two output latches, which feed the analog converters, are then refreshed in one of two ways. In the immediate way, the written channel updates as soon as its word is complete. In the deferred way, every channel written since the last refresh updates in the same cycle, triggered by a falling edge on a separate load strobe.

All serial pins are brought into one fast system clock. Each passes through a synchronizer chain and an edge detector. The system clock must run at least eight times faster than the serial clock. An active-low clear input acts asynchronously. It empties the shift register and zeroes every holding latch, every output latch and any pending refresh. The level of a format pin is passed through to a mode output, for use by the analog stage.

Top module: `dual_dac_loader`

## Requirements
- R1: A falling edge on `sync_ni` restarts the bit count and arms the frame. Each falling edge of `sclk_i` while armed shifts in `sdin_i`, first bit as frame bit 15.
- R2: After the 16th serial clock fall the frame is locked. Further serial clock edges before the next `sync_ni` fall change nothing. `frame_done_o` goes high once 16 bits are in and stays high until the next frame starts.
- R3: Frame bits 15..13 have no effect. Bit 12 picks the channel: 0 selects A and 1 selects B. Bits 11..0 are the code, and bit 0 is sent last.
- R4: If `ldac_i` is low when `sync_ni` falls, the frame is immediate. The selected channel's output code takes the new value once the 16th bit is in, and the other channel keeps its code.
- R5: If `ldac_i` is high when `sync_ni` falls, the frame is deferred and no output changes at its end. The next falling edge of `ldac_i` refreshes, in the same cycle, every channel written by a deferred frame since the last refresh.
- R6: On a deferred refresh, a channel with no deferred write since the last refresh keeps its previous output code.
- R7: If `sync_ni` rises before the 16th bit, the partial frame is dropped. No latch changes and `frame_done_o` stays low.
- R8: While `clr_ni` (or `rst_ni`) is low, both output codes are zero and `frame_done_o` is low. Holding latches and pending refreshes are also emptied, so a later `ldac_i` fall still gives zero.
- R9: `twos_mode_o` follows `fmt_i`: 0 means straight or offset binary, and 1 means twos complement.
- R10: A falling edge of `ldac_i` with no deferred write pending leaves both output codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Asynchronous clear of latches and shifter, active low |
| sync_ni | input | 1 | Frame strobe, active low |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sdin_i | input | 1 | Serial data |
| ldac_i | input | 1 | Load strobe; its level selects the mode, its fall refreshes |
| fmt_i | input | 1 | Code format select |
| code_a_o | output | CODE_W | Output latch code of channel A |
| code_b_o | output | CODE_W | Output latch code of channel B |
| frame_done_o | output | 1 | A full 16-bit frame has been received |
| twos_mode_o | output | 1 | Format mode: 1 = twos complement |

## Verification
The bench builds the block with its default parameters: a 12-bit code, three padding bits and two synchronizer stages. These values give the 16-bit frame that the stimulus encodes. With them, every code value, every pad pattern and both channel-select values can be reached. A serial clock of eight system clocks per period keeps the two-stage synchronizers within their rate limit. Some frames are padded with extra serial clocks to exercise the lock-out. Frames are also cut short, and the load strobe is toggled between and across frames, so that immediate and deferred refreshes mix on the same channel.

// File: rtl/dsl_pkg.sv
`timescale 1ns/1ps
package dsl_pkg;
   localparam int NUM_CH = 2;
   localparam int CH_W   = 1;
   // bit order of the synchronized pin vector
   localparam int PIN_SYNC = 0;
   localparam int PIN_SCLK = 1;
   localparam int PIN_SDIN = 2;
   localparam int PIN_LDAC = 3;
   localparam int NUM_PINS = 4;
endpackage

// File: rtl/dsl_sync.sv
`timescale 1ns/1ps
module dsl_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] fall_o
);
   logic [WIDTH-1:0] last_q;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (k == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) r <= RST_VAL;
            else         r <= d_i;
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni)
            if (!rst_ni) r <= RST_VAL;
            else         r <= g_stage[k-1].r;
      end
   end

   assign q_o = g_stage[STAGES-1].r;

   always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) last_q <= RST_VAL;
      else         last_q <= q_o;

   assign fall_o = last_q & ~q_o;
endmodule

// File: rtl/dsl_shifter.sv
`timescale 1ns/1ps
module dsl_shifter #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               sync_lvl_i,
   input  logic               sync_fall_i,
   input  logic               sclk_fall_i,
   input  logic               sdin_i,
   input  logic               ldac_lvl_i,
   output logic [FRAME_W-1:0] word_o,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               wr_stb_o,
   output logic               auto_o,
   output logic               done_o
);
   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_o   <= '0;
         cnt_o    <= '0;
         wr_stb_o <= 1'b0;
         auto_o   <= 1'b0;
         done_o   <= 1'b0;
         armed_q  <= 1'b0;
      end else begin
         wr_stb_o <= 1'b0;
         if (sync_fall_i) begin
            cnt_o   <= '0;
            armed_q <= 1'b1;
            done_o  <= 1'b0;
            auto_o  <= ~ldac_lvl_i;
         end else if (armed_q && sync_lvl_i) begin
            armed_q <= 1'b0;              // partial frame dropped
         end else if (armed_q && sclk_fall_i) begin
            word_o <= {word_o[FRAME_W-2:0], sdin_i};
            cnt_o  <= cnt_o + 1'b1;
            if (cnt_o == CNT_W'(FRAME_W - 1)) begin
               armed_q  <= 1'b0;          // gate closes
               done_o   <= 1'b1;
               wr_stb_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsl_latches.sv
`timescale 1ns/1ps
module dsl_latches
   import dsl_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_stb_i,
   input  logic [CH_W-1:0]          sel_i,
   input  logic [CODE_W-1:0]        code_i,
   input  logic                     auto_i,
   input  logic                     ldac_fall_i,
   output logic [NUM_CH*CODE_W-1:0] out_o,
   output logic [NUM_CH-1:0]        pend_o,
   output logic                     upd_stb_o
);
   assign upd_stb_o = ldac_fall_i & (|pend_o);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CODE_W-1:0] hold_q, out_q;
      logic              pend_q, hit;

      assign hit = wr_stb_i && (sel_i == CH_W'(c));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hold_q <= '0;
            out_q  <= '0;
            pend_q <= 1'b0;
         end else if (hit) begin
            hold_q <= code_i;
            if (auto_i) out_q  <= code_i;
            else        pend_q <= 1'b1;
         end else if (ldac_fall_i && pend_q) begin
            out_q  <= hold_q;
            pend_q <= 1'b0;
         end
      end

      assign out_o[c*CODE_W +: CODE_W] = out_q;
      assign pend_o[c] = pend_q;
   end
endmodule

// File: rtl/dual_dac_loader.sv
`timescale 1ns/1ps
module dual_dac_loader
   import dsl_pkg::*;
#(
   parameter int CODE_W      = 12,
   parameter int PAD_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W    = PAD_W + 1 + CODE_W,
   localparam int CNT_W      = $clog2(FRAME_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_ni,
   input  logic              sync_ni,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic              ldac_i,
   input  logic              fmt_i,
   output logic [CODE_W-1:0] code_a_o,
   output logic [CODE_W-1:0] code_b_o,
   output logic              frame_done_o,
   output logic              twos_mode_o
);
   if (CODE_W < 2)      $error("CODE_W must be at least 2");
   if (PAD_W < 1)       $error("PAD_W must be at least 1");
   if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");

   logic                     areset_n;
   logic [NUM_PINS-1:0]      pin_raw, pin_q, pin_fall;
   logic [FRAME_W-1:0]       word;
   logic [CNT_W-1:0]         cnt;
   logic                     wr_stb, auto_mode, upd_stb;
   logic [NUM_CH*CODE_W-1:0] out_flat;
   logic [NUM_CH-1:0]        pend;
   logic                     unused_bits;

   assign areset_n = rst_ni & clr_ni;

   assign pin_raw[PIN_SYNC] = sync_ni;
   assign pin_raw[PIN_SCLK] = sclk_i;
   assign pin_raw[PIN_SDIN] = sdin_i;
   assign pin_raw[PIN_LDAC] = ldac_i;

   dsl_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES),
      .RST_VAL(NUM_PINS'(4'b1011))
   ) i_sync (
      .clk_i (clk_i),
      .rst_ni(areset_n),
      .d_i   (pin_raw),
      .q_o   (pin_q),
      .fall_o(pin_fall)
   );

   dsl_shifter #(.FRAME_W(FRAME_W)) i_shift (
      .clk_i      (clk_i),
      .rst_ni     (areset_n),
      .sync_lvl_i (pin_q[PIN_SYNC]),
      .sync_fall_i(pin_fall[PIN_SYNC]),
      .sclk_fall_i(pin_fall[PIN_SCLK]),
      .sdin_i     (pin_q[PIN_SDIN]),
      .ldac_lvl_i (pin_q[PIN_LDAC]),
      .word_o     (word),
      .cnt_o      (cnt),
      .wr_stb_o   (wr_stb),
      .auto_o     (auto_mode),
      .done_o     (frame_done_o)
   );

   dsl_latches #(.CODE_W(CODE_W)) i_latch (
      .clk_i      (clk_i),
      .rst_ni     (areset_n),
      .wr_stb_i   (wr_stb),
      .sel_i      (word[CODE_W +: CH_W]),
      .code_i     (word[CODE_W-1:0]),
      .auto_i     (auto_mode),
      .ldac_fall_i(pin_fall[PIN_LDAC]),
      .out_o      (out_flat),
      .pend_o     (pend),
      .upd_stb_o  (upd_stb)
   );

   assign code_a_o    = out_flat[CODE_W-1:0];
   assign code_b_o    = out_flat[2*CODE_W-1:CODE_W];
   assign twos_mode_o = fmt_i;
   assign unused_bits = ^{word[FRAME_W-1:CODE_W+CH_W], pin_fall[PIN_SDIN]};
endmodule

// File: rtl/dsl_checker.sv
`timescale 1ns/1ps
module dsl_checker #(
   parameter int CODE_W  = 12,
   parameter int FRAME_W = 16,
   parameter int CNT_W   = 5
) (
   input logic              clk_i,
   input logic              areset_n,
   input logic [CODE_W-1:0] code_a_o,
   input logic [CODE_W-1:0] code_b_o,
   input logic              frame_done_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              sync_fall,
   input logic              wr_stb,
   input logic              auto_mode,
   input logic              upd_stb,
   input logic [1:0]        pend
);
   a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!areset_n)
      cnt <= CNT_W'(FRAME_W));

   a_r2_locked: assert property (@(posedge clk_i) disable iff (!areset_n)
      (frame_done_o && !sync_fall) |=> $stable(cnt));

   a_r1_done_full: assert property (@(posedge clk_i) disable iff (!areset_n)
      $rose(frame_done_o) |-> cnt == CNT_W'(FRAME_W));

   a_r4_out_cause: assert property (@(posedge clk_i) disable iff (!areset_n)
      !$stable({code_b_o, code_a_o}) |-> $past(wr_stb || upd_stb));

   a_r5_deferred_hold: assert property (@(posedge clk_i) disable iff (!areset_n)
      (wr_stb && !auto_mode && !upd_stb) |=> $stable({code_b_o, code_a_o}));

   a_r5_pending_clear: assert property (@(posedge clk_i) disable iff (!areset_n)
      (upd_stb && !wr_stb) |=> pend == 2'b00);
endmodule

bind dual_dac_loader dsl_checker #(
   .CODE_W (CODE_W),
   .FRAME_W(FRAME_W),
   .CNT_W  (CNT_W)
) i_dsl_checker (
   .clk_i       (clk_i),
   .areset_n    (areset_n),
   .code_a_o    (code_a_o),
   .code_b_o    (code_b_o),
   .frame_done_o(frame_done_o),
   .cnt         (cnt),
   .sync_fall   (pin_fall[0]),
   .wr_stb      (wr_stb),
   .auto_mode   (auto_mode),
   .upd_stb     (upd_stb),
   .pend        (pend)
);

// File: tb/test_dual_dac_loader.sv
`timescale 1ns/1ps
module test_dual_dac_loader;
   logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1;
   logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0, ldac = 1'b1, fmt = 1'b0;
   logic [11:0] code_a, code_b;
   logic done, twos;

   int checks = 0, errors = 0;
   logic [11:0] exp_out [2];
   logic [11:0] exp_hold [2];
   logic        exp_pend [2];
   logic        exp_done;

   always #10 clk = ~clk;

   dual_dac_loader i_dual_dac_loader (
      .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .sync_ni(sync_n),
      .sclk_i(sclk), .sdin_i(sdin), .ldac_i(ldac), .fmt_i(fmt),
      .code_a_o(code_a), .code_b_o(code_b), .frame_done_o(done),
      .twos_mode_o(twos));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check(req, 32'(code_a), 32'(exp_out[0]));
      check(req, 32'(code_b), 32'(exp_out[1]));
      check(req, 32'(done), 32'(exp_done));
   endtask

   function automatic void model_clear();
      for (int c = 0; c < 2; c++) begin
         exp_out[c] = '0; exp_hold[c] = '0; exp_pend[c] = 1'b0;
      end
      exp_done = 1'b0;
   endfunction

   function automatic void model_refresh();
      for (int c = 0; c < 2; c++)
         if (exp_pend[c]) begin exp_out[c] = exp_hold[c]; exp_pend[c] = 1'b0; end
   endfunction

   function automatic void model_frame(input logic [15:0] w, input logic immediate);
      int c = int'(w[12]);
      exp_hold[c] = w[11:0];
      if (immediate) exp_out[c] = w[11:0];
      else           exp_pend[c] = 1'b1;
      exp_done = 1'b1;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ldac(input logic v);
      if (ldac && !v) model_refresh();
      ldac = v;
      wait_clk(8);
   endtask

   task automatic pulse_ldac();
      set_ldac(1'b0);
      set_ldac(1'b1);
   endtask

   // sends nbits bits of w (MSB first), then extra garbage clocks
   task automatic send(input logic [15:0] w, input int nbits, input int extra);
      @(negedge clk) sync_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < nbits + extra; i++) begin
         sdin = (i < nbits) ? w[15-i] : 1'($urandom);
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(4);
         sclk = 1'b1;
      end
      wait_clk(4);
      sync_n = 1'b1;
      wait_clk(8);
   endtask

   initial begin : main
      void'($urandom(32'd7249));
      model_clear();
      wait_clk(4);
      check_all("R8 reset");
      rst_n = 1'b1;
      wait_clk(4);

      // immediate frame to A, pad bits set
      set_ldac(1'b0);
      send(16'hEABC, 16, 0); model_frame(16'hEABC, 1'b1);
      check_all("R1 R3 R4 immediate A");

      // immediate frame to B with extra clocks after 16 bits
      send(16'h1123, 16, 5); model_frame(16'h1123, 1'b1);
      check_all("R2 locked after 16 bits");
      check("R3 channel B code", 32'(code_b), 32'h123);

      // deferred writes to both channels
      set_ldac(1'b1);
      send(16'h0555, 16, 0); model_frame(16'h0555, 1'b0);
      check_all("R5 deferred A no change");
      send(16'hF666, 16, 0); model_frame(16'hF666, 1'b0);
      check_all("R5 deferred B no change");
      pulse_ldac();
      check_all("R5 refresh both");
      check("R5 A after refresh", 32'(code_a), 32'h555);

      // deferred write to A only
      send(16'h0777, 16, 0); model_frame(16'h0777, 1'b0);
      pulse_ldac();
      check_all("R6 B keeps code");
      check("R6 B value", 32'(code_b), 32'h666);

      // partial frame
      send(16'h1FFF, 10, 0); exp_done = 1'b0;
      check_all("R7 partial dropped");
      pulse_ldac();
      check_all("R10 refresh with none pending");

      // format pass-through
      fmt = 1'b1; wait_clk(2);
      check("R9 twos mode high", 32'(twos), 32'd1);
      fmt = 1'b0; wait_clk(2);
      check("R9 twos mode low", 32'(twos), 32'd0);

      // clear with pending deferred write
      send(16'h1ACE, 16, 0); model_frame(16'h1ACE, 1'b0);
      clr_n = 1'b0; model_clear();
      wait_clk(3);
      check_all("R8 clear active");
      clr_n = 1'b1;
      wait_clk(4);
      pulse_ldac();
      check_all("R8 nothing pending after clear");

      // random mix
      for (int n = 0; n < 60; n++) begin
         logic [15:0] w = 16'($urandom);
         logic imm = 1'($urandom);
         int extra = int'($urandom_range(0, 3));
         set_ldac(!imm);
         if ($urandom_range(0, 7) == 0) begin
            send(w, int'($urandom_range(1, 15)), 0);
            exp_done = 1'b0;
            check_all("R7 random partial");
         end else begin
            send(w, 16, extra); model_frame(w, imm);
            check_all(imm ? "R4 random immediate" : "R5 random deferred");
         end
         if (!imm && $urandom_range(0, 2) == 0) begin
            pulse_ldac();
            check_all("R6 random refresh");
         end
      end
      set_ldac(1'b0);
      check_all("R5 refresh on mode change");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule